// File: doc/BRIEF.md
# Carry-Aware Eight-Operation ALU

This block is the execute-stage arithmetic unit of a small 16-bit core. Each cycle it takes a 3-bit operation code, a source register value and the operand register value. From these it forms a 16-bit result, a register write enable and a destination index. It also holds the carry and zero flags. Seven of the operation codes produce a value to write back to a register. The eighth is a store: it turns the source value into write data and the operand value into the write address, and it writes no register.

The sequencer drives `exec_en` for one cycle during its execute state. It drives `pred_ok` when the instruction's predicate passed. The flags change only at the clock edge that ends such a cycle. The result and the store outputs are combinational, so the sequencer must sample them in that same cycle.

The reset input is asserted asynchronously and released through a short synchronizer. The flags therefore leave reset two clock edges after `rst_n` rises.

Top module: `alu16_exec`

## Requirements
- R1: `op_sel` carries instruction bits [10:8]. Code 000 (load) drives `result` equal to `opnd_val` and leaves the carry flag unchanged.
- R2: Code 001 (add) drives `result` = `src_val` + `opnd_val` mod 2^16. On an update, the carry flag takes the carry out of bit 15.
- R3: Code 110 (add with carry) drives `result` = `src_val` + `opnd_val` + the carry flag mod 2^16. On an update, the carry flag takes the carry out of bit 15.
- R4: Codes 010, 011 and 100 drive the bitwise AND, OR and XOR of `src_val` and `opnd_val`, and they leave the carry flag unchanged.
- R5: Code 101 rotates `opnd_val` right by one place through carry. The result is {carry flag, `opnd_val`[15:1]}, and on an update the carry flag takes `opnd_val`[0].
- R6: On an update by any code other than 111, the zero flag becomes 1 exactly when the 16-bit result is zero.
- R7: Code 111 (store) asserts `store_req` and drives `store_data` = `src_val` and `store_addr` = `opnd_val`. It keeps `reg_we` low and leaves both flags unchanged.
- R8: When `exec_en` or `pred_ok` is low, `reg_we` and `store_req` are low and both flags hold their values.
- R9: `reg_we` stays low when `dest_sel` is 0, so register 0 is never written. `dest_idx` always equals `dest_sel`.
- R10: While reset is applied, the carry flag and the zero flag are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (instruction bits [10:8]) |
| dest_sel | input | 4 | Destination register index |
| src_val | input | 16 | Source register value |
| opnd_val | input | 16 | Operand register value |
| exec_en | input | 1 | Execute-state strobe |
| pred_ok | input | 1 | Predicate of the current instruction passed |
| result | output | 16 | Write-back value |
| reg_we | output | 1 | Register write enable |
| dest_idx | output | 4 | Register index to write |
| store_req | output | 1 | Store operation active this cycle |
| store_data | output | 16 | Data to write to memory |
| store_addr | output | 16 | Memory address for the store |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |

## Verification
The embedded assertions check the cycle-level rules on every cycle. Flags hold when no update occurs. A store never raises a register write, and register 0 never receives a write. The zero flag and the rotate carry follow the result and the operand bit of the cycle before. Only the bench scenarios can show the arithmetic values themselves: sums with and without an incoming carry, the carry out of bit 15, the three bitwise results and the bit entering the rotate from the flag. The same holds for the reset values of the flags and for a carry surviving a chain of load and logic operations.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_LD  = 3'b000,
    OP_ADD = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_ROR = 3'b101,
    OP_ADC = 3'b110,
    OP_STO = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu16_rst_sync.sv
module alu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           carry_in,
  output logic [W-1:0]   res,
  output logic           carry_out,
  output logic           carry_wr
);
  logic [W:0] sum_ext;
  logic       add_cin;

  always_comb begin
    add_cin = (op == OP_ADC) ? carry_in : 1'b0;
    sum_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, add_cin};
  end

  always_comb begin
    res       = b;
    carry_out = carry_in;
    carry_wr  = 1'b0;
    unique case (op)
      OP_LD:  res = b;
      OP_ADD, OP_ADC: begin
        res       = sum_ext[W-1:0];
        carry_out = sum_ext[W];
        carry_wr  = 1'b1;
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_ROR: begin
        res       = {carry_in, b[W-1:1]};
        carry_out = b[0];
        carry_wr  = 1'b1;
      end
      OP_STO: res = a;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         carry_wr,
  input  logic         carry_nx,
  input  logic [W-1:0] res,
  output logic         carry_q,
  output logic         zero_q
);
  logic carry_d, zero_d;

  always_comb begin
    carry_d = carry_q;
    zero_d  = zero_q;
    if (upd) begin
      if (carry_wr) carry_d = carry_nx;
      zero_d = (res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      carry_q <= carry_d;
      zero_q  <= zero_d;
    end
  end

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(carry_q) && $stable(zero_q)));

  // R6
  zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (zero_q == ($past(res) == '0)));

  // R4
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !carry_wr) |=> $stable(carry_q));
endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int W       = 16,
  parameter int RIDX    = 4,
  parameter int OPW     = 3,
  parameter int SYNC_ST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  op_sel,
  input  logic [RIDX-1:0] dest_sel,
  input  logic [W-1:0]    src_val,
  input  logic [W-1:0]    opnd_val,
  input  logic            exec_en,
  input  logic            pred_ok,
  output logic [W-1:0]    result,
  output logic            reg_we,
  output logic [RIDX-1:0] dest_idx,
  output logic            store_req,
  output logic [W-1:0]    store_data,
  output logic [W-1:0]    store_addr,
  output logic            carry_q,
  output logic            zero_q
);
  localparam logic [RIDX-1:0] ZERO_REG = '0;

  logic    rst_n_sync;
  alu_op_e op;
  logic    fire, is_store, flag_upd;
  logic    carry_nx, carry_wr;

  alu16_rst_sync #(.STAGES(SYNC_ST)) i_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  always_comb begin
    op       = alu_op_e'(op_sel);
    fire     = exec_en && pred_ok;
    is_store = (op == OP_STO);
    flag_upd = fire && !is_store;
  end

  alu16_core #(.W(W)) i_core (
    .op        (op),
    .a         (src_val),
    .b         (opnd_val),
    .carry_in  (carry_q),
    .res       (result),
    .carry_out (carry_nx),
    .carry_wr  (carry_wr)
  );

  alu16_flags #(.W(W)) i_flags (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .upd      (flag_upd),
    .carry_wr (carry_wr),
    .carry_nx (carry_nx),
    .res      (result),
    .carry_q  (carry_q),
    .zero_q   (zero_q)
  );

  always_comb begin
    dest_idx   = dest_sel;
    reg_we     = fire && !is_store && (dest_sel != ZERO_REG);
    store_req  = fire && is_store;
    store_data = src_val;
    store_addr = opnd_val;
  end

  // R7
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    store_req |-> !reg_we);

  // R9
  r0_protect_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    reg_we |-> (dest_idx != ZERO_REG));

  // R5
  ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (exec_en && pred_ok && op_sel == 3'b101) |=> (carry_q == $past(opnd_val[0])));

  // R7
  store_flags_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    store_req |=> ($stable(carry_q) && $stable(zero_q)));
endmodule

// File: tb/test_alu16_exec.sv
module test_alu16_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [3:0]  dest_sel;
  logic [15:0] src_val, opnd_val;
  logic        exec_en, pred_ok;
  logic [15:0] result, store_data, store_addr;
  logic        reg_we, store_req, carry_q, zero_q;
  logic [3:0]  dest_idx;

  int checks = 0;
  int failures = 0;
  logic exp_c, exp_z;

  always #2 clk = ~clk;

  alu16_exec i_alu16_exec (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dest_sel(dest_sel),
    .src_val(src_val), .opnd_val(opnd_val), .exec_en(exec_en), .pred_ok(pred_ok),
    .result(result), .reg_we(reg_we), .dest_idx(dest_idx), .store_req(store_req),
    .store_data(store_data), .store_addr(store_addr), .carry_q(carry_q), .zero_q(zero_q)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation at a negedge, check comb outputs, then flags after the edge
  task automatic do_op(string req, logic [2:0] op, logic [3:0] d, logic [15:0] s,
                       logic [15:0] o, logic en, logic pr);
    logic [16:0] sum;
    logic [15:0] r;
    logic        nc, upd, ok_we;
    @(negedge clk);
    op_sel = op; dest_sel = d; src_val = s; opnd_val = o; exec_en = en; pred_ok = pr;
    nc = exp_c;
    case (op)
      3'b000: r = o;
      3'b001: begin sum = {1'b0, s} + {1'b0, o}; r = sum[15:0]; nc = sum[16]; end
      3'b110: begin sum = {1'b0, s} + {1'b0, o} + {16'd0, exp_c}; r = sum[15:0]; nc = sum[16]; end
      3'b010: r = s & o;
      3'b011: r = s | o;
      3'b100: r = s ^ o;
      3'b101: begin r = {exp_c, o[15:1]}; nc = o[0]; end
      default: r = s;
    endcase
    upd   = en && pr && (op != 3'b111);
    ok_we = upd && (d != 4'd0);
    #1;
    if (op != 3'b111) chk({req, " result"}, result, r);
    chk({req, " reg_we"}, {15'd0, reg_we}, {15'd0, ok_we});
    chk({req, " store_req"}, {15'd0, store_req}, {15'd0, en && pr && (op == 3'b111)});
    chk({req, " dest_idx"}, {12'd0, dest_idx}, {12'd0, d});
    if (op == 3'b111) begin
      chk({req, " store_data"}, store_data, s);
      chk({req, " store_addr"}, store_addr, o);
    end
    if (upd) begin
      exp_c = nc;
      exp_z = (r == 16'd0);
    end
    @(negedge clk);
    exec_en = 1'b0;
    chk({req, " carry"}, {15'd0, carry_q}, {15'd0, exp_c});
    chk({req, " zero"}, {15'd0, zero_q}, {15'd0, exp_z});
  endtask

  task automatic t_reset;
    chk("R10 carry after reset", {15'd0, carry_q}, 16'd0);
    chk("R10 zero after reset", {15'd0, zero_q}, 16'd0);
  endtask

  task automatic t_load_logic;
    do_op("R1 load", 3'b000, 4'd3, 16'h1234, 16'hBEEF, 1, 1);
    do_op("R6 load zero", 3'b000, 4'd3, 16'h1234, 16'h0000, 1, 1);
    do_op("R4 and", 3'b010, 4'd5, 16'hF0F0, 16'h3C3C, 1, 1);
    do_op("R4 or", 3'b011, 4'd5, 16'hF000, 16'h000F, 1, 1);
    do_op("R4 xor", 3'b100, 4'd5, 16'hA5A5, 16'hA5A5, 1, 1);
  endtask

  task automatic t_add;
    do_op("R2 add no carry", 3'b001, 4'd2, 16'h0001, 16'h0002, 1, 1);
    do_op("R2 add carry out", 3'b001, 4'd2, 16'hFFFF, 16'h0001, 1, 1);
    do_op("R4 and keeps carry", 3'b010, 4'd2, 16'hFFFF, 16'h00FF, 1, 1);
    do_op("R3 adc with carry", 3'b110, 4'd2, 16'h0010, 16'h0020, 1, 1);
    do_op("R3 adc wrap", 3'b110, 4'd2, 16'h8000, 16'h8000, 1, 1);
    do_op("R3 adc carry in", 3'b110, 4'd2, 16'hFFFF, 16'h0000, 1, 1);
  endtask

  task automatic t_ror;
    do_op("R5 ror low bit set", 3'b101, 4'd7, 16'h0000, 16'h0003, 1, 1);
    do_op("R5 ror carry in", 3'b101, 4'd7, 16'h0000, 16'h0002, 1, 1);
    do_op("R5 ror zero", 3'b101, 4'd7, 16'h0000, 16'h0001, 1, 1);
  endtask

  task automatic t_store;
    do_op("R1 load set", 3'b000, 4'd1, 16'h0, 16'h0000, 1, 1);
    do_op("R2 add set carry", 3'b001, 4'd1, 16'hFFFF, 16'h0002, 1, 1);
    do_op("R7 store", 3'b111, 4'd9, 16'hCAFE, 16'h0000, 1, 1);
    do_op("R7 store second", 3'b111, 4'd4, 16'h0000, 16'h4000, 1, 1);
  endtask

  task automatic t_gating;
    do_op("R8 exec low", 3'b001, 4'd6, 16'hFFFF, 16'hFFFF, 0, 1);
    do_op("R8 pred fail", 3'b000, 4'd6, 16'h0, 16'h0000, 1, 0);
    do_op("R8 pred fail store", 3'b111, 4'd6, 16'h1111, 16'h2222, 1, 0);
    do_op("R9 dest zero", 3'b011, 4'd0, 16'h0F00, 16'h00F0, 1, 1);
    do_op("R9 dest fifteen", 3'b011, 4'd15, 16'h0F00, 16'h00F0, 1, 1);
  endtask

  initial begin
    rst_n = 1'b0; op_sel = '0; dest_sel = '0; src_val = '0; opnd_val = '0;
    exec_en = 1'b0; pred_ok = 1'b0;
    exp_c = 1'b0; exp_z = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_logic();
    t_add();
    t_ror();
    t_store();
    t_gating();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule